// File: doc/BRIEF.md
# Flash Array Program/Erase Controller

This block models a small non-volatile byte array on a simple single-cycle CPU bus, together with the control logic that programs and erases it. Reads return one byte or a 16-bit big-endian word straight from the array. A plain write to the array never stores anything. It can only load a one-shot programming latch, and only after software has armed that latch through the control register.

A program or erase is a short register sequence. Software sets the arm bit and picks program or erase with the erase-select bit. It then writes the target address and data to the array, which captures them in the latch. Finally it sets the high-voltage enable bit while keeping arm set. After a fixed, parameterized wait, a program ANDs the latched data into the target location, so bits can only go from 1 to 0. An erase sets every bit of the array back to 1. A done flag in the control register then rises. What an array read returns depends on the arm, erase-select and enable bits, so software can watch the location it is about to program.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, the done flag is low, and every array byte reads 0xFF.
- R2: With all control bits clear, a byte read returns {8'h00, byte[a]}, and a word read returns {byte[a], byte[a+1]} (lower address in bits 15:8).
- R3: With the arm bit (control bit 0) clear, an array write changes no array byte.
- R4: With arm set and the latch empty, the first array write captures its address, size and data. Later array writes leave the latch unchanged for as long as arm stays set.
- R5: A word write to an odd address while arm is set is rejected and leaves the latch empty, so a following aligned write is captured.
- R6: With enable (control bit 2) clear, arm set, erase-select (control bit 1) clear and the latch full, an array read returns the latched location at the latched size, whatever the bus address. With erase-select set, the same read is a normal read.
- R7: While enable is set, an array read returns the parameter IDLE_DATA.
- R8: A control write that sets enable while arm is set and the latch is full, with erase-select clear, starts a program. On the PE_CYCLES-th rising edge after the write, each target byte becomes old AND new (a word at an even address a writes data bits 15:8 to a and bits 7:0 to a+1), and the done flag (control bit 3) goes high.
- R9: The same sequence with erase-select set sets every array byte to 0xFF when the wait ends, and raises done.
- R10: A control write that sets enable and clears arm in the same access starts nothing. Done stays low and the array is unchanged.
- R11: A control write with arm clear empties the latch, so the next armed write is captured afresh.
- R12: The control register reads back at any time as {12'h000, done, enable, erase-select, arm}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_sel | input | 1 | Access targets the control register |
| arr_sel | input | 1 | Access targets the array |
| bus_wr | input | 1 | Write strobe for the selected target |
| bus_addr | input | ADDR_W | Byte address in the array |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected target (combinational) |
| pe_done | output | 1 | Program or erase has completed; cleared when enable or arm drops |

## Verification
The bench builds the block with ADDR_W = 4 and PE_CYCLES = 5. With a 16-byte array, the bench can read back every location after an erase and can mix byte and word accesses across the same few bytes. The five-cycle wait lets it check done on the exact edge it should rise and on the edge before. IDLE_DATA is set to 0xA5A5, a value no array location takes in the test, so a read gated by the enable bit cannot be mistaken for real data.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   localparam int DATA_W   = 16;
   localparam int BYTE_W   = 8;

   // control register bit positions (software decodes these)
   localparam int CB_ARM   = 0;
   localparam int CB_ERS   = 1;
   localparam int CB_HV    = 2;
   localparam int CB_DONE  = 3;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
   import nvm_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              arr_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_word,
   input  logic [DATA_W-1:0] wdata,
   output logic              arm_q,
   output logic              ers_q,
   output logic              hv_q,
   output logic              lat_full,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              lat_word,
   output logic [DATA_W-1:0] lat_data,
   output logic              start
);

   logic capture;

   always_comb begin
      capture = arr_wr && arm_q && !lat_full && !(wr_word && wr_addr[0]);
      start   = ctl_wr && wdata[CB_HV] && wdata[CB_ARM] && !hv_q && lat_full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         ers_q <= 1'b0;
         hv_q  <= 1'b0;
      end else if (ctl_wr) begin
         arm_q <= wdata[CB_ARM];
         ers_q <= wdata[CB_ERS];
         hv_q  <= wdata[CB_HV];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_full <= 1'b0;
         lat_addr <= '0;
         lat_word <= 1'b0;
         lat_data <= '0;
      end else if (ctl_wr && !wdata[CB_ARM]) begin
         lat_full <= 1'b0;
      end else if (capture) begin
         lat_full <= 1'b1;
         lat_addr <= wr_addr;
         lat_word <= wr_word;
         lat_data <= wdata;
      end
   end

   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_full && arm_q && arr_wr && !ctl_wr)
      |=> ($stable(lat_addr) && $stable(lat_data) && $stable(lat_word) && lat_full));

   p_latch_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wdata[CB_ARM]) |=> !lat_full);

   p_misalign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr && !ctl_wr && !lat_full && wr_word && wr_addr[0]) |=> !lat_full);

endmodule

// File: rtl/nvm_pe_seq.sv
module nvm_pe_seq
   import nvm_pkg::*;
#(
   parameter int PE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic arm_q,
   input  logic ers_q,
   input  logic hv_q,
   output logic prog_stb,
   output logic erase_stb,
   output logic done
);

   localparam int CNT_W = (PE_CYCLES > 1) ? $clog2(PE_CYCLES) : 1;

   seq_state_e state_q;
   logic       expire;
   logic       hold;
   logic       apply;

   if (PE_CYCLES < 1) begin : g_bad_cycles
      $error("nvm_pe_seq: PE_CYCLES must be at least 1");
   end

   if (PE_CYCLES == 1) begin : g_no_timer
      always_comb expire = 1'b1;
   end else begin : g_timer
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)               cnt_q <= '0;
         else if (start)           cnt_q <= '0;
         else if (state_q == SQ_WAIT) cnt_q <= cnt_q + 1'b1;
      end
      always_comb expire = (cnt_q == CNT_W'(PE_CYCLES - 1));
   end

   always_comb begin
      hold      = hv_q && arm_q;
      apply     = (state_q == SQ_WAIT) && hold && expire;
      prog_stb  = apply && !ers_q;
      erase_stb = apply && ers_q;
      done      = (state_q == SQ_DONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (start) state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (!hold)      state_q <= SQ_IDLE;
               else if (apply) state_q <= SQ_DONE;
            end
            SQ_DONE: if (!hold) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
   import nvm_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_stb,
   input  logic              erase_stb,
   input  logic [ADDR_W-1:0] pgm_addr,
   input  logic              pgm_word,
   input  logic [DATA_W-1:0] pgm_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_hi,
   output logic [BYTE_W-1:0] rd_lo
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem_q [DEPTH];
   logic [ADDR_W-1:0] pair_addr;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_depth
      $error("nvm_cell_array: ADDR_W must lie in 2..12");
   end

   always_comb pair_addr = {pgm_addr[ADDR_W-1:1], 1'b1};

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      logic hit_hi;
      logic hit_lo;
      logic [BYTE_W-1:0] new_byte;

      always_comb begin
         hit_hi   = prog_stb && (pgm_addr == ADDR_W'(r));
         hit_lo   = prog_stb && pgm_word && (pair_addr == ADDR_W'(r));
         new_byte = (hit_hi && pgm_word) ? pgm_data[15:8] : pgm_data[7:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                mem_q[r] <= '1;
         else if (erase_stb)        mem_q[r] <= '1;
         else if (hit_hi || hit_lo) mem_q[r] <= mem_q[r] & new_byte;
      end

      p_prog_only_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !erase_stb |=> ((mem_q[r] & ~$past(mem_q[r])) == '0));

      p_idle_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!prog_stb && !erase_stb) |=> $stable(mem_q[r]));
   end

   always_comb begin
      rd_hi = mem_q[rd_addr];
      rd_lo = mem_q[rd_addr + 1'b1];
   end

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
   import nvm_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          PE_CYCLES = 16,
   parameter logic [15:0] IDLE_DATA = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_sel,
   input  logic              arr_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_word,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              pe_done
);

   logic              ctl_wr, arr_wr;
   logic              arm_q, ers_q, hv_q;
   logic              lat_full, lat_word, start;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;
   logic              prog_stb, erase_stb;
   logic              show_latch;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_word;
   logic [BYTE_W-1:0] rd_hi, rd_lo;

   always_comb begin
      ctl_wr     = ctl_sel && bus_wr;
      arr_wr     = arr_sel && bus_wr && !ctl_sel;
      show_latch = arm_q && !ers_q && lat_full;
      rd_addr    = show_latch ? lat_addr : bus_addr;
      rd_word    = show_latch ? lat_word : bus_word;
   end

   nvm_ctl_reg #(.ADDR_W(ADDR_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .arr_wr   (arr_wr),
      .wr_addr  (bus_addr),
      .wr_word  (bus_word),
      .wdata    (bus_wdata),
      .arm_q    (arm_q),
      .ers_q    (ers_q),
      .hv_q     (hv_q),
      .lat_full (lat_full),
      .lat_addr (lat_addr),
      .lat_word (lat_word),
      .lat_data (lat_data),
      .start    (start)
   );

   nvm_pe_seq #(.PE_CYCLES(PE_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .arm_q     (arm_q),
      .ers_q     (ers_q),
      .hv_q      (hv_q),
      .prog_stb  (prog_stb),
      .erase_stb (erase_stb),
      .done      (pe_done)
   );

   nvm_cell_array #(.ADDR_W(ADDR_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_stb  (prog_stb),
      .erase_stb (erase_stb),
      .pgm_addr  (lat_addr),
      .pgm_word  (lat_word),
      .pgm_data  (lat_data),
      .rd_addr   (rd_addr),
      .rd_hi     (rd_hi),
      .rd_lo     (rd_lo)
   );

   always_comb begin
      if (ctl_sel)
         bus_rdata = {12'h000, pe_done, hv_q, ers_q, arm_q};
      else if (!arr_sel)
         bus_rdata = '0;
      else if (hv_q)
         bus_rdata = IDLE_DATA;
      else if (rd_word)
         bus_rdata = {rd_hi, rd_lo};
      else
         bus_rdata = {8'h00, rd_hi};
   end

   p_no_start_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[CB_HV] && !bus_wdata[CB_ARM] && !pe_done) |=> !pe_done);

endmodule

// File: tb/nvm_prog_ctrl_tb.sv
module nvm_prog_ctrl_tb;

   localparam int          AW   = 4;
   localparam int          PEC  = 5;
   localparam logic [15:0] IDLE = 16'hA5A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_sel = 1'b0, arr_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic          pe_done;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   nvm_prog_ctrl #(.ADDR_W(AW), .PE_CYCLES(PEC), .IDLE_DATA(IDLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .arr_sel(arr_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_word(bus_word),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pe_done(pe_done)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ctl_write(input logic [15:0] d);
      @(negedge clk);
      ctl_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      ctl_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic arr_write(input logic [AW-1:0] a, input logic w, input logic [15:0] d);
      @(negedge clk);
      arr_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_word = w; bus_wdata = d;
      @(negedge clk);
      arr_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic arr_read(input logic [AW-1:0] a, input logic w, output logic [15:0] d);
      arr_sel = 1'b1; bus_addr = a; bus_word = w;
      #1 d = bus_rdata;
      arr_sel = 1'b0;
   endtask

   task automatic ctl_read(output logic [15:0] d);
      ctl_sel = 1'b1;
      #1 d = bus_rdata;
      ctl_sel = 1'b0;
   endtask

   // ENPE written at the task's edge; done due on the PEC-th edge after it
   task automatic wait_done(input string req);
      idle(PEC - 1);
      check({req, " done not yet"}, {15'h0, pe_done}, 16'h0000);
      idle(1);
      check({req, " done on time"}, {15'h0, pe_done}, 16'h0001);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      ctl_read(d);
      check("R1 ctl", d, 16'h0000);
      check("R1 done", {15'h0, pe_done}, 16'h0000);
      for (int a = 0; a < 16; a += 2) begin
         arr_read(AW'(a), 1'b1, d);
         check("R1 erased", d, 16'hFFFF);
      end
   endtask

   task automatic t_plain_write();
      logic [15:0] d;
      arr_write(4'd2, 1'b1, 16'h1234);
      arr_write(4'd6, 1'b0, 16'h0000);
      arr_read(4'd2, 1'b1, d);  check("R3 word ignored", d, 16'hFFFF);
      arr_read(4'd6, 1'b0, d);  check("R3 byte ignored", d, 16'h00FF);
   endtask

   task automatic t_prog_byte();
      logic [15:0] d;
      ctl_write(16'h0001);
      arr_write(4'd3, 1'b0, 16'hFF5A);
      arr_write(4'd5, 1'b0, 16'h0000);          // R4 second write dropped
      ctl_write(16'h0005);
      arr_read(4'd3, 1'b0, d);  check("R7 idle read", d, IDLE);
      wait_done("R8 byte");
      ctl_read(d);              check("R12 ctl readback", d, 16'h000D);
      ctl_write(16'h0000);
      idle(1);
      check("R8 done cleared", {15'h0, pe_done}, 16'h0000);
      arr_read(4'd3, 1'b0, d);  check("R8 byte programmed", d, 16'h005A);
      arr_read(4'd5, 1'b0, d);  check("R4 later write ignored", d, 16'h00FF);
   endtask

   task automatic t_latch_view();
      logic [15:0] d;
      ctl_write(16'h0001);
      arr_write(4'd7, 1'b0, 16'h000F);
      arr_read(4'd3, 1'b0, d);  check("R6 shows latched loc", d, 16'h00FF);
      ctl_write(16'h0003);
      arr_read(4'd3, 1'b0, d);  check("R6 erase-select normal", d, 16'h005A);
      ctl_write(16'h0001);
      arr_write(4'd3, 1'b0, 16'h0000);          // R4 dropped, latch holds 7
      ctl_write(16'h0000);
      arr_read(4'd3, 1'b0, d);  check("R11 latch emptied", d, 16'h005A);
      ctl_write(16'h0001);
      arr_write(4'd9, 1'b0, 16'h00F0);
      ctl_write(16'h0005);
      wait_done("R11 refill");
      ctl_write(16'h0000);
      idle(1);
      arr_read(4'd9, 1'b0, d);  check("R11 new target", d, 16'h00F0);
      arr_read(4'd7, 1'b0, d);  check("R11 old target untouched", d, 16'h00FF);
      arr_read(4'd3, 1'b0, d);  check("R4 held write dropped", d, 16'h005A);
   endtask

   task automatic t_prog_word();
      logic [15:0] d;
      ctl_write(16'h0001);
      arr_write(4'd5, 1'b1, 16'h1234);
      arr_read(4'd3, 1'b1, d);  check("R5 misaligned rejected", d, 16'h5AFF);
      arr_write(4'd4, 1'b1, 16'h0FF0);
      arr_read(4'd3, 1'b1, d);  check("R5 aligned captured", d, 16'hFFFF);
      ctl_write(16'h0005);
      wait_done("R8 word");
      ctl_write(16'h0000);
      idle(1);
      arr_read(4'd4, 1'b1, d);  check("R2 R8 word order", d, 16'h0FF0);
      arr_read(4'd5, 1'b0, d);  check("R2 byte lo", d, 16'h00F0);
      ctl_write(16'h0001);
      arr_write(4'd4, 1'b1, 16'hF00F);
      ctl_write(16'h0005);
      wait_done("R8 reprogram");
      ctl_write(16'h0000);
      idle(1);
      arr_read(4'd4, 1'b1, d);  check("R8 bits only cleared", d, 16'h0000);
   endtask

   task automatic t_no_start();
      logic [15:0] d;
      ctl_write(16'h0001);
      arr_write(4'd3, 1'b0, 16'h0000);
      ctl_write(16'h0004);
      idle(PEC + 3);
      check("R10 no done", {15'h0, pe_done}, 16'h0000);
      ctl_write(16'h0000);
      arr_read(4'd3, 1'b0, d);  check("R10 array unchanged", d, 16'h005A);
   endtask

   task automatic t_erase();
      logic [15:0] d;
      ctl_write(16'h0003);
      arr_write(4'd0, 1'b0, 16'h0000);
      ctl_write(16'h0007);
      wait_done("R9 erase");
      ctl_write(16'h0000);
      idle(1);
      for (int a = 0; a < 16; a += 2) begin
         arr_read(AW'(a), 1'b1, d);
         check("R9 all ones", d, 16'hFFFF);
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_plain_write();
      t_prog_byte();
      t_latch_view();
      t_prog_word();
      t_no_start();
      t_erase();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule